// File: doc/BRIEF.md
# Narrow-Access Register Bridge with Deferred Command Flush

This bridge connects a host bus that issues byte, half-word and word register accesses to a peripheral register file that only understands full 32-bit reads and writes at word-aligned addresses. Narrow writes become a peripheral read, a lane merge and a full-word write-back. Narrow reads fetch the whole word and return the addressed lane right-justified.

Three half-word registers get special handling: the block-length half and block-count half of the word at offset 0x04, and the transfer-setup half at offset 0x0C. Writes to them are held in two shadow words inside the bridge. The peripheral sees nothing until the host writes the command half at offset 0x0E. That write sends the pending block word first and then the merged transfer-setup/command word, as two separate 32-bit writes. This keeps any two writes to the same peripheral word from arriving close together. Reads of a shadowed half return the shadow copy while it is pending.

When low-speed spacing is enabled, every peripheral write is followed by a stall. The stall lasts four card-clock periods, with each period given as a programmable count of bridge clock cycles. If that count is zero, a fixed fallback stall is used instead. The host handshake holds ready low for the whole of each multi-cycle sequence and stall.

Top module: `regw_coalesce_bridge`

## Requirements
- R1: Every peripheral access is a 32-bit access whose address has bits [1:0] equal to zero. A host word write (h_size=2) is passed straight through as one peripheral write of h_wdata, with no peripheral read first.
- R2: A narrow write that is not shadowed reads the peripheral word and replaces only the addressed lane, then writes the whole word back. The lane starts at bit 8*h_addr[1:0]. It is 8 bits wide for h_size=0 and 16 bits wide for h_size=1.
- R3: A narrow read returns the addressed lane shifted down to bit 0, with zeros above it. A word read returns the full word.
- R4: A half write (h_size=1) to offset 0x04 or 0x06 updates the block shadow word and produces no peripheral write. The merge starts from the shadow word when that shadow is pending. Otherwise it starts from a peripheral read.
- R5: A half write to offset 0x0C reads the peripheral word at 0x0C and merges the value into the low half. The result is kept in the command shadow word, which becomes pending. No peripheral write happens.
- R6: A half write to offset 0x0E does two things in order. First, if the block shadow is pending, it writes the block shadow word to 0x04. Then it merges the value into the high half of the command shadow word (not a peripheral read) and writes that to 0x0C. Both pending flags are cleared.
- R7: A half read of 0x0C while the command shadow is pending, or of 0x04/0x06 while the block shadow is pending, returns the lane from the shadow. Every other read, including word reads, goes to the peripheral.
- R8: Byte writes (h_size=0) are never shadowed, including those inside the words at 0x04 and 0x0C. They always do a peripheral read-modify-write and leave the shadow words unchanged.
- R9: With cfg_slow_en=1, two peripheral writes are at least S+1 cycles apart, where S = 4*cfg_period, or FALLBACK when cfg_period=0. With cfg_slow_en=0 there is no stall, and a flush pair is at most 3 cycles apart.
- R10: After reset h_ready is 1, nothing is pending and the shadow words are zero. h_ready is 0 during every peripheral access, stall and read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_slow_en | input | 1 | Enables post-write spacing |
| cfg_period | input | CNT_W | Card-clock period in bridge cycles; 0 selects the fallback stall |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can accept a request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 half, 2 word |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Write value, right-justified |
| h_rdata | output | 32 | Read value, right-justified |
| h_rvalid | output | 1 | One-cycle pulse with read data |
| p_req | output | 1 | Peripheral access strobe |
| p_we | output | 1 | Peripheral write when 1 |
| p_addr | output | ADDR_W | Word-aligned peripheral address |
| p_wdata | output | 32 | Peripheral write word |
| p_rdata | input | 32 | Peripheral read word, valid the cycle after a read strobe |

## Verification
The hardest state to reach is a command write that arrives while both shadows are pending and hold values that differ from the peripheral. Only then do the flush order and the choice of merge source show up at the ports. The bench gets there in several steps. It first plants distinct words at 0x04 and 0x0C with word writes, then fills both shadows with half writes. It then overwrites the peripheral copy of 0x0C behind the shadow's back, so that a merge from the wrong source gives a visibly different word. Spacing is measured between logged peripheral write strobes with each stall mode selected in turn.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_BLK   = 2'd1,
    K_XFER  = 2'd2,
    K_CMD   = 2'd3
  } kind_e;

  function automatic logic [4:0] lane_shift(input logic [1:0] lo);
    return {lo, 3'b000};
  endfunction

  function automatic logic [31:0] lane_base(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Replace the addressed lane of old_w with val.
  function automatic logic [31:0] merge_lane(input logic [31:0] old_w,
                                             input logic [31:0] val,
                                             input logic [1:0]  sz,
                                             input logic [1:0]  lo);
    logic [31:0] base;
    logic [4:0]  sh;
    base = lane_base(sz);
    sh   = lane_shift(lo);
    if (sz == SZ_WORD) return val;
    return (old_w & ~(base << sh)) | ((val & base) << sh);
  endfunction

  // Extract the addressed lane, right-justified.
  function automatic logic [31:0] pick_lane(input logic [31:0] w,
                                            input logic [1:0]  sz,
                                            input logic [1:0]  lo);
    if (sz == SZ_WORD) return w;
    return (w >> lane_shift(lo)) & lane_base(sz);
  endfunction

  function automatic int unsigned stall_cycles(input logic        slow,
                                               input int unsigned period,
                                               input int unsigned fallback);
    if (!slow) return 0;
    if (period == 0) return fallback;
    return 4 * period;
  endfunction

endpackage

// File: rtl/rcb_spacer.sv
module rcb_spacer #(
  parameter int CNT_W    = 12,
  parameter int FALLBACK = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_slow_en,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic             start,
  output logic             busy
);
  import rcb_pkg::*;

  localparam int SP_W = CNT_W + 3;

  logic [SP_W-1:0] cnt;
  logic [SP_W-1:0] load_val;

  always_comb load_val = SP_W'(stall_cycles(cfg_slow_en, 32'(cfg_period), FALLBACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rcb_shadow.sv
module rcb_shadow (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_ld,
  input  logic [31:0] blk_din,
  input  logic        blk_clr,
  input  logic        cmd_ld,
  input  logic [31:0] cmd_din,
  input  logic        cmd_vld_din,
  output logic [31:0] blk_word,
  output logic [31:0] cmd_word,
  output logic        blk_vld,
  output logic        cmd_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_word <= '0;
      blk_vld  <= 1'b0;
    end else if (blk_ld) begin
      blk_word <= blk_din;
      blk_vld  <= 1'b1;
    end else if (blk_clr) begin
      blk_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word <= '0;
      cmd_vld  <= 1'b0;
    end else if (cmd_ld) begin
      cmd_word <= cmd_din;
      cmd_vld  <= cmd_vld_din;
    end
  end
endmodule

// File: rtl/rcb_ctrl.sv
module rcb_ctrl #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BLK_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] XFER_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [1:0]        h_size,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              h_rvalid,
  output logic              p_req,
  output logic              p_we,
  output logic [ADDR_W-1:0] p_addr,
  output logic [31:0]       p_wdata,
  input  logic [31:0]       p_rdata,
  input  logic [31:0]       blk_word,
  input  logic [31:0]       cmd_word,
  input  logic              blk_vld,
  input  logic              cmd_vld,
  output logic              blk_ld,
  output logic [31:0]       blk_din,
  output logic              blk_clr,
  output logic              cmd_ld,
  output logic [31:0]       cmd_din,
  output logic              cmd_vld_din,
  output logic              sp_start,
  input  logic              sp_busy,
  output logic              ev_flush,
  output logic              ev_cmd_wr
);
  import rcb_pkg::*;

  typedef enum logic [2:0] {
    S_IDLE, S_PRD, S_PCAP, S_BLKWR, S_WR, S_WAIT, S_RESP
  } state_e;

  localparam int WA_W = ADDR_W - 2;

  function automatic kind_e classify(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    if (sz != SZ_HALF)                        return K_PLAIN;
    if (a[ADDR_W-1:2] == BLK_OFS[ADDR_W-1:2]) return K_BLK;
    if (a == XFER_OFS)                        return K_XFER;
    if (a == CMD_OFS)                         return K_CMD;
    return K_PLAIN;
  endfunction

  function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  state_e            state;
  logic              op_we;
  logic [1:0]        op_size;
  logic [ADDR_W-1:0] op_addr;
  logic [31:0]       op_wdata;
  kind_e             op_kind;
  logic [31:0]       m_word;
  logic [31:0]       rdata_q;
  logic              ret_wr;

  logic  acc;
  kind_e acc_kind;
  logic  shadow_hit;
  logic [31:0] shadow_src;
  logic [31:0] cmd_merged;
  logic [31:0] cap_merged;

  always_comb begin
    acc        = (state == S_IDLE) && h_valid;
    acc_kind   = classify(h_addr, h_size);
    shadow_hit = (acc_kind == K_XFER && cmd_vld) || (acc_kind == K_BLK && blk_vld);
    shadow_src = (acc_kind == K_XFER) ? cmd_word : blk_word;
    cmd_merged = merge_lane(cmd_word, h_wdata, h_size, h_addr[1:0]);
    cap_merged = merge_lane(p_rdata, op_wdata, op_size, op_addr[1:0]);
  end

  // Shadow update controls
  always_comb begin
    blk_ld      = 1'b0;
    blk_din     = cap_merged;
    cmd_ld      = 1'b0;
    cmd_din     = cap_merged;
    cmd_vld_din = 1'b1;
    if (acc && h_write && acc_kind == K_BLK && blk_vld) begin
      blk_ld  = 1'b1;
      blk_din = merge_lane(blk_word, h_wdata, h_size, h_addr[1:0]);
    end else if (state == S_PCAP && op_we && op_kind == K_BLK) begin
      blk_ld  = 1'b1;
    end
    if (acc && h_write && acc_kind == K_CMD) begin
      cmd_ld      = 1'b1;
      cmd_din     = cmd_merged;
      cmd_vld_din = 1'b0;
    end else if (state == S_PCAP && op_we && op_kind == K_XFER) begin
      cmd_ld      = 1'b1;
    end
  end

  assign blk_clr   = (state == S_BLKWR);
  assign h_ready   = (state == S_IDLE);
  assign h_rvalid  = (state == S_RESP);
  assign h_rdata   = rdata_q;
  assign p_req     = (state == S_PRD) || (state == S_BLKWR) || (state == S_WR);
  assign p_we      = (state == S_BLKWR) || (state == S_WR);
  assign p_addr    = (state == S_BLKWR) ? word_of(BLK_OFS) : word_of(op_addr);
  assign p_wdata   = (state == S_BLKWR) ? blk_word : m_word;
  assign sp_start  = p_req && p_we;
  assign ev_flush  = (state == S_BLKWR);
  assign ev_cmd_wr = (state == S_WR) && (op_kind == K_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_we    <= 1'b0;
      op_size  <= 2'd0;
      op_addr  <= '0;
      op_wdata <= '0;
      op_kind  <= K_PLAIN;
      m_word   <= '0;
      rdata_q  <= '0;
      ret_wr   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (acc) begin
          op_we    <= h_write;
          op_size  <= h_size;
          op_addr  <= h_addr;
          op_wdata <= h_wdata;
          op_kind  <= acc_kind;
          if (!h_write) begin
            if (shadow_hit) begin
              rdata_q <= pick_lane(shadow_src, h_size, h_addr[1:0]);
              state   <= S_RESP;
            end else begin
              state   <= S_PRD;
            end
          end else if (h_size == SZ_WORD) begin
            m_word <= h_wdata;
            state  <= S_WR;
          end else begin
            case (acc_kind)
              K_BLK:   state <= blk_vld ? S_IDLE : S_PRD;
              K_CMD: begin
                m_word <= cmd_merged;
                state  <= blk_vld ? S_BLKWR : S_WR;
              end
              default: state <= S_PRD;
            endcase
          end
        end
        S_PRD:  state <= S_PCAP;
        S_PCAP: begin
          if (!op_we) begin
            rdata_q <= pick_lane(p_rdata, op_size, op_addr[1:0]);
            state   <= S_RESP;
          end else if (op_kind == K_BLK || op_kind == K_XFER) begin
            state   <= S_IDLE;
          end else begin
            m_word  <= cap_merged;
            state   <= S_WR;
          end
        end
        S_BLKWR: begin
          ret_wr <= 1'b1;
          state  <= S_WAIT;
        end
        S_WR: begin
          ret_wr <= 1'b0;
          state  <= S_WAIT;
        end
        S_WAIT: if (!sp_busy) state <= ret_wr ? S_WR : S_IDLE;
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regw_coalesce_bridge.sv
module regw_coalesce_bridge #(
  parameter int                ADDR_W   = 8,
  parameter int                CNT_W    = 12,
  parameter int                FALLBACK = 40,
  parameter logic [ADDR_W-1:0] BLK_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] XFER_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slow_en,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [1:0]        h_size,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              h_rvalid,
  output logic              p_req,
  output logic              p_we,
  output logic [ADDR_W-1:0] p_addr,
  output logic [31:0]       p_wdata,
  input  logic [31:0]       p_rdata
);
  logic [31:0] blk_word, cmd_word, blk_din, cmd_din;
  logic        blk_vld, cmd_vld, blk_ld, blk_clr, cmd_ld, cmd_vld_din;
  logic        sp_start, sp_busy, ev_flush, ev_cmd_wr;

  rcb_ctrl #(
    .ADDR_W(ADDR_W), .BLK_OFS(BLK_OFS), .XFER_OFS(XFER_OFS), .CMD_OFS(CMD_OFS)
  ) u_ctrl (
    .clk, .rst_n, .h_valid, .h_ready, .h_write, .h_size, .h_addr, .h_wdata,
    .h_rdata, .h_rvalid, .p_req, .p_we, .p_addr, .p_wdata, .p_rdata,
    .blk_word, .cmd_word, .blk_vld, .cmd_vld, .blk_ld, .blk_din, .blk_clr,
    .cmd_ld, .cmd_din, .cmd_vld_din, .sp_start, .sp_busy, .ev_flush, .ev_cmd_wr
  );

  rcb_shadow u_shadow (
    .clk, .rst_n, .blk_ld, .blk_din, .blk_clr, .cmd_ld, .cmd_din, .cmd_vld_din,
    .blk_word, .cmd_word, .blk_vld, .cmd_vld
  );

  rcb_spacer #(.CNT_W(CNT_W), .FALLBACK(FALLBACK)) u_spacer (
    .clk, .rst_n, .cfg_slow_en, .cfg_period, .start(sp_start), .busy(sp_busy)
  );
endmodule

// File: rtl/rcb_checker.sv
module rcb_checker #(
  parameter int                ADDR_W   = 8,
  parameter int                CNT_W    = 12,
  parameter int                FALLBACK = 40,
  parameter logic [ADDR_W-1:0] BLK_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] XFER_OFS = 8'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_slow_en,
  input logic [CNT_W-1:0]  cfg_period,
  input logic              h_valid,
  input logic              h_ready,
  input logic              h_write,
  input logic [1:0]        h_size,
  input logic [ADDR_W-1:0] h_addr,
  input logic              h_rvalid,
  input logic              p_req,
  input logic              p_we,
  input logic [ADDR_W-1:0] p_addr,
  input logic              blk_vld,
  input logic              cmd_vld,
  input logic              ev_flush,
  input logic              ev_cmd_wr
);
  import rcb_pkg::*;

  logic              pwr;
  logic [31:0]       gap_cnt;
  logic              seen_wr;
  logic              cfg_slow_q;
  logic [CNT_W-1:0]  cfg_period_q;
  int unsigned       need;

  assign pwr  = p_req && p_we;
  always_comb need = stall_cycles(cfg_slow_en, 32'(cfg_period), FALLBACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt      <= '0;
      seen_wr      <= 1'b0;
      cfg_slow_q   <= 1'b0;
      cfg_period_q <= '0;
    end else begin
      cfg_slow_q   <= cfg_slow_en;
      cfg_period_q <= cfg_period;
      if ((cfg_slow_q != cfg_slow_en) || (cfg_period_q != cfg_period)) seen_wr <= 1'b0;
      else if (pwr) seen_wr <= 1'b1;
      if (pwr) gap_cnt <= '0;
      else if (gap_cnt != 32'hFFFF_FFFF) gap_cnt <= gap_cnt + 1;
    end
  end

  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    p_req |-> (p_addr[1:0] == 2'b00));

  assert_blk_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && h_write && h_size == 2'd1 &&
     h_addr[ADDR_W-1:2] == BLK_OFS[ADDR_W-1:2]) |=> !pwr);

  assert_flush_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |-> (pwr && p_addr == {BLK_OFS[ADDR_W-1:2], 2'b00}));

  assert_cmd_after_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_wr |-> (!blk_vld && !cmd_vld && pwr && p_addr == XFER_OFS));

  assert_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr && seen_wr && (cfg_slow_q == cfg_slow_en) && (cfg_period_q == cfg_period))
      |-> (gap_cnt >= need));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req || h_rvalid) |-> !h_ready);
endmodule

bind regw_coalesce_bridge rcb_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FALLBACK(FALLBACK),
  .BLK_OFS(BLK_OFS), .XFER_OFS(XFER_OFS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_slow_en(cfg_slow_en), .cfg_period(cfg_period),
  .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_size(h_size),
  .h_addr(h_addr), .h_rvalid(h_rvalid), .p_req(p_req), .p_we(p_we),
  .p_addr(p_addr), .blk_vld(blk_vld), .cmd_vld(cmd_vld),
  .ev_flush(ev_flush), .ev_cmd_wr(ev_cmd_wr)
);

// File: tb/test_regw_coalesce_bridge.sv
module test_regw_coalesce_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_slow_en = 1'b0;
  logic [11:0] cfg_period = '0;
  logic        h_valid = 1'b0, h_write = 1'b0;
  logic [1:0]  h_size = '0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_rvalid, p_req, p_we;
  logic [31:0] h_rdata, p_wdata;
  logic [7:0]  p_addr;
  logic [31:0] p_rdata = '0;

  always #4 clk = ~clk;

  regw_coalesce_bridge i_regw_coalesce_bridge (
    .clk, .rst_n, .cfg_slow_en, .cfg_period, .h_valid, .h_ready, .h_write,
    .h_size, .h_addr, .h_wdata, .h_rdata, .h_rvalid, .p_req, .p_we, .p_addr,
    .p_wdata, .p_rdata
  );

  // Peripheral model with write log
  logic [31:0] mem [64];
  logic [7:0]  wr_addr [256];
  logic [31:0] wr_data [256];
  int          wr_cyc  [256];
  int          wr_n = 0;
  int          cyc = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (p_req) begin
      if (p_we) begin
        mem[p_addr[7:2]] <= p_wdata;
        if (wr_n < 256) begin
          wr_addr[wr_n] = p_addr;
          wr_data[wr_n] = p_wdata;
          wr_cyc[wr_n]  = cyc;
        end
        wr_n = wr_n + 1;
      end else begin
        p_rdata <= mem[p_addr[7:2]];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [1:0] sz, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    q = '0;
    @(negedge clk);
    h_valid = 1'b1; h_write = we; h_size = sz; h_addr = a; h_wdata = d;
    while (!h_ready) @(negedge clk);
    @(negedge clk);
    h_valid = 1'b0;
    if (!we) begin
      while (!h_rvalid) @(negedge clk);
      q = h_rdata;
    end
    while (!h_ready) @(negedge clk);
  endtask

  // {we, size, addr, wdata, expected read}
  localparam logic [74:0] VEC [10] = '{
    {1'b1, 2'd2, 8'h20, 32'h1122_3344, 32'h0},
    {1'b0, 2'd2, 8'h20, 32'h0,         32'h1122_3344},
    {1'b1, 2'd0, 8'h21, 32'h0000_00AA, 32'h0},
    {1'b0, 2'd2, 8'h20, 32'h0,         32'h1122_AA44},
    {1'b1, 2'd1, 8'h22, 32'h0000_BEEF, 32'h0},
    {1'b0, 2'd2, 8'h20, 32'h0,         32'hBEEF_AA44},
    {1'b0, 2'd0, 8'h23, 32'h0,         32'h0000_00BE},
    {1'b0, 2'd1, 8'h20, 32'h0,         32'h0000_AA44},
    {1'b1, 2'd0, 8'h27, 32'h0000_005A, 32'h0},
    {1'b0, 2'd2, 8'h24, 32'h0,         32'h5A00_0000}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] q;
    int n0, t0, bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 ready in reset", {31'b0, h_ready}, 32'd1);
    chk("R10 no peripheral access in reset", {31'b0, p_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", {31'b0, h_ready}, 32'd1);
    chk("R10 no rvalid after reset", {31'b0, h_rvalid}, 32'd0);
    // R3 / R7: reset shadow not pending, read goes to peripheral (zero)
    acc(0, 2'd1, 8'h0C, 0, q); chk("R7 reset read 0x0C", q, 32'h0);

    // Table: plain lane merges (R2) and lane reads (R3), word path (R1)
    for (int i = 0; i < 10; i++) begin
      acc(VEC[i][74], VEC[i][73:72], VEC[i][71:64], VEC[i][63:32], q);
      if (!VEC[i][74]) chk("R2/R3 table read R3", q, VEC[i][31:0]);
    end

    // Shadow scenario
    acc(1, 2'd2, 8'h04, 32'h0003_0040, q);
    acc(1, 2'd2, 8'h0C, 32'h1234_0000, q);
    n0 = wr_n;
    acc(1, 2'd1, 8'h04, 32'h0200, q);
    chk("R4 no write for block half", wr_n, n0);
    acc(0, 2'd1, 8'h04, 0, q); chk("R7 block shadow read", q, 32'h0200);
    acc(0, 2'd2, 8'h04, 0, q); chk("R7 word read from peripheral", q, 32'h0003_0040);
    acc(1, 2'd1, 8'h06, 32'h0010, q);
    acc(0, 2'd1, 8'h06, 0, q); chk("R4 count merged in shadow", q, 32'h0010);
    acc(1, 2'd1, 8'h0C, 32'h0013, q);
    chk("R5 no write for transfer half", wr_n, n0);
    acc(0, 2'd1, 8'h0C, 0, q); chk("R7 command shadow read", q, 32'h0013);
    acc(0, 2'd1, 8'h0E, 0, q); chk("R7 command half from peripheral", q, 32'h1234);
    acc(1, 2'd1, 8'h0E, 32'h113A, q);
    chk("R6 two writes", wr_n, n0 + 2);
    chk("R6 flush addr", {24'b0, wr_addr[n0]}, 32'h04);
    chk("R6 flush data", wr_data[n0], 32'h0010_0200);
    chk("R6 cmd addr", {24'b0, wr_addr[n0+1]}, 32'h0C);
    chk("R6 cmd data", wr_data[n0+1], 32'h113A_0013);
    acc(0, 2'd1, 8'h0C, 0, q); chk("R7 after flush from peripheral", q, 32'h0013);
    acc(0, 2'd1, 8'h06, 0, q); chk("R7 count from peripheral", q, 32'h0010);

    // R6: command merges from command shadow, not peripheral
    acc(1, 2'd2, 8'h0C, 32'hFFFF_FFFF, q);
    n0 = wr_n;
    acc(1, 2'd1, 8'h0E, 32'h0D00, q);
    chk("R6 single write without block", wr_n, n0 + 1);
    chk("R6 cmd merge source", wr_data[n0], 32'h0D00_0013);

    // R8: byte writes never shadowed
    n0 = wr_n;
    acc(1, 2'd0, 8'h05, 32'h77, q);
    chk("R8 byte write count", wr_n, n0 + 1);
    chk("R8 byte rmw data", wr_data[n0], 32'h0010_7700);
    acc(1, 2'd1, 8'h06, 32'h0005, q);
    n0 = wr_n;
    acc(1, 2'd0, 8'h04, 32'h11, q);
    chk("R8 byte write with shadow pending", wr_data[n0], 32'h0010_7711);
    acc(0, 2'd1, 8'h04, 0, q); chk("R8 shadow untouched by byte", q, 32'h7700);
    n0 = wr_n;
    acc(1, 2'd1, 8'h0E, 32'h0001, q);
    chk("R6 flush after byte", wr_data[n0], 32'h0005_7700);
    chk("R6 cmd after byte", wr_data[n0+1], 32'h0001_0013);

    // R9 / R10: spacing
    cfg_slow_en = 1'b1; cfg_period = 12'd5;
    repeat (2) @(negedge clk);
    acc(1, 2'd1, 8'h04, 32'h0001, q);
    n0 = wr_n; t0 = cyc;
    acc(1, 2'd1, 8'h0E, 32'h0002, q);
    chk("R9 flush pair gap >= 21", {31'b0, (wr_cyc[n0+1] - wr_cyc[n0]) >= 21}, 32'd1);
    chk("R10 ready held low through stalls", {31'b0, (cyc - t0) >= 40}, 32'd1);
    acc(1, 2'd2, 8'h20, 32'h1, q);
    chk("R9 next op gap >= 21", {31'b0, (wr_cyc[n0+2] - wr_cyc[n0+1]) >= 21}, 32'd1);
    cfg_period = 12'd0;
    repeat (2) @(negedge clk);
    n0 = wr_n;
    acc(1, 2'd2, 8'h20, 32'h2, q);
    acc(1, 2'd2, 8'h24, 32'h3, q);
    chk("R9 fallback gap >= 41", {31'b0, (wr_cyc[n0+1] - wr_cyc[n0]) >= 41}, 32'd1);
    cfg_slow_en = 1'b0;
    repeat (2) @(negedge clk);
    acc(1, 2'd1, 8'h04, 32'h0009, q);
    n0 = wr_n;
    acc(1, 2'd1, 8'h0E, 32'h0003, q);
    chk("R9 no stall when disabled", {31'b0, (wr_cyc[n0+1] - wr_cyc[n0]) <= 3}, 32'd1);

    // R1: all logged write addresses aligned
    bad = 0;
    for (int i = 0; i < wr_n && i < 256; i++) if (wr_addr[i][1:0] != 2'b00) bad++;
    chk("R1 aligned write addresses", bad, 0);
    acc(0, 2'd2, 8'h24, 0, q); chk("R1 word write passthrough", q, 32'h3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule